// File: doc/BRIEF.md
# High-Speed Lane Burst Sequencer

This block is the transmit-side controller for one serial data lane. While the lane is idle it holds both single-ended low-power lines high. A request on `start` moves the lane through a two-step low-power entry. A fixed eight-slot leader then marks where the payload begins. Payload bytes from a valid/ready stream follow, serialized one bit per clock, and an inverted trailing level closes the burst before the lane returns to its idle state.

Each clock carries one high-speed bit slot, which drives one edge of the lane's double-data-rate clock. The two low-power request states each last `LP_HOLD` cycles. The trailing level lasts `TRAIL_LEN` cycles. Payload is taken only in whole bytes. The stream must supply the next byte at the moment it is asked for. If it does not, the burst is closed early and a one-cycle underflow flag is raised.

Top module: `hs_lane_seq`

## Requirements
- R1: After reset and while no burst is running, `lp_p`=1, `lp_n`=1, `hs_en`=0, `hs_bit`=0, `in_ready`=0 and `underflow`=0.
- R2: When `start` is sampled high in the idle state, the lines show `lp_p`=0/`lp_n`=1 for `LP_HOLD` cycles, starting the next cycle. They then show 0/0 for `LP_HOLD` cycles with `hs_en` still 0.
- R3: Whenever `hs_en` is 1, both `lp_p` and `lp_n` are 0.
- R4: The first eight high-speed slots carry the leader 0,0,0,1,1,1,0,1 in that serial order, ahead of any payload bit.
- R5: Each accepted byte occupies exactly eight consecutive slots and is sent least significant bit first (bit 0 first, bit 7 last). No partial byte is ever sent.
- R6: `in_ready` is 1 for exactly one cycle before each byte: the last leader slot, or the bit-7 slot of a byte that was not flagged `in_last`. A byte is taken on that cycle's edge when `in_valid` is 1.
- R7: After bit 7 of the byte flagged `in_last`, `hs_bit` holds the inverse of that bit for `TRAIL_LEN` cycles with `hs_en`=1.
- R8: In the cycle after the trailing level ends, `hs_en`=0 and the lines show 1/1. The lane then stays idle while `start` is low.
- R9: If `in_valid` is 0 on a cycle where `in_ready` is 1, no byte is taken. The trailing level follows at once for `TRAIL_LEN` cycles, holding the inverse of the last bit sent (a leader-only burst trails 0). `underflow` is 1 in the first trailing cycle only.
- R10: `start` has no effect while a burst is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request, sampled in the idle state |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte present |
| in_last | input | 1 | Marks the final byte of the burst |
| in_ready | output | 1 | Byte taken this edge when `in_valid` is high |
| lp_p | output | 1 | Low-power level of the positive line |
| lp_n | output | 1 | Low-power level of the negative line |
| hs_en | output | 1 | High-speed driver enable |
| hs_bit | output | 1 | Serial high-speed bit for the current slot |
| underflow | output | 1 | One-cycle flag: burst cut short for lack of data |

## Verification
Every output is decoded from registered state. Each result therefore appears in the cycle that follows the edge which caused it. The first 0/1 line level is due one cycle after `start` is sampled, and the leader starts 2·`LP_HOLD` cycles later. Payload bit k of byte b lands at a fixed offset of 8·b+k slots after the leader. The trail and `underflow` follow the slot of the last bit with no gap. The bench builds each expected cycle arithmetically from that offset and samples on the falling edge, half a period after the edge that produced the value. It drives the next byte only after the rising edge on which `in_ready` and `in_valid` were both seen high.

// File: rtl/hs_lane_pkg.sv
package hs_lane_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ASK,
      PH_BRIDGE,
      PH_LEADER,
      PH_PAYLOAD,
      PH_TRAIL
   } lane_phase_e;

   // bit s is the level sent in leader slot s (slot 0 first)
   localparam logic [7:0] LEADER_SERIAL = 8'b1011_1000;

   localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/lane_hold_timer.sv
module lane_hold_timer #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] span,
   output logic [W-1:0] remaining,
   output logic         expiring
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= span - 1'b1;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign remaining = cnt_q;
   assign expiring  = (cnt_q == '0);

   // every held state lasts at least one cycle
   assert_span_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (span != '0));

endmodule

// File: rtl/lane_byte_shifter.sv
module lane_byte_shifter #(
   parameter int unsigned W         = 8,
   parameter bit          MSB_FIRST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic         bit_o
);

   logic [W-1:0] sr_q;
   logic [W-1:0] sr_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_o   = sr_q[W-1];
         assign sr_next = {sr_q[W-2:0], 1'b0};
      end else begin : g_lsb
         assign bit_o   = sr_q[0];
         assign sr_next = {1'b0, sr_q[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         sr_q <= '0;
      else if (load)
         sr_q <= din;
      else if (shift)
         sr_q <= sr_next;
   end

   assert_load_excl_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !shift);

endmodule

// File: rtl/hs_lane_seq.sv
module hs_lane_seq
   import hs_lane_pkg::*;
#(
   parameter int unsigned LP_HOLD   = 2,
   parameter int unsigned TRAIL_LEN = 3,
   parameter bit          MSB_FIRST = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   input  logic       in_last,
   output logic       in_ready,
   output logic       lp_p,
   output logic       lp_n,
   output logic       hs_en,
   output logic       hs_bit,
   output logic       underflow
);

   localparam int unsigned BYTE_W   = BYTE_BITS;
   localparam int unsigned MAX_A    = (LP_HOLD > TRAIL_LEN) ? LP_HOLD : TRAIL_LEN;
   localparam int unsigned MAX_SPAN = (MAX_A > BYTE_W) ? MAX_A : BYTE_W;
   localparam int unsigned SPAN_W   = $clog2(MAX_SPAN + 1);

   generate
      if (LP_HOLD < 1) begin : g_bad_hold
         $error("LP_HOLD must be at least 1");
      end
      if (TRAIL_LEN < 1) begin : g_bad_trail
         $error("TRAIL_LEN must be at least 1");
      end
   endgenerate

   lane_phase_e        phase_q, phase_d;
   logic               tmr_load;
   logic [SPAN_W-1:0]  tmr_span;
   logic [SPAN_W-1:0]  slot;
   logic               slot_end;
   logic               sh_load, sh_shift, sh_bit;
   logic               last_q, trail_q, uf_q, uf_d;
   logic               cur_bit;
   logic [2:0]         lead_idx;

   lane_hold_timer #(.W(SPAN_W)) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tmr_load),
      .span      (tmr_span),
      .remaining (slot),
      .expiring  (slot_end)
   );

   lane_byte_shifter #(.W(BYTE_W), .MSB_FIRST(MSB_FIRST)) shifter_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sh_load),
      .shift (sh_shift),
      .din   (in_data),
      .bit_o (sh_bit)
   );

   assign in_ready = slot_end &&
                     ((phase_q == PH_LEADER) || ((phase_q == PH_PAYLOAD) && !last_q));

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_span = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      uf_d     = 1'b0;
      case (phase_q)
         PH_IDLE: begin
            if (start) begin
               phase_d  = PH_ASK;
               tmr_load = 1'b1;
               tmr_span = SPAN_W'(LP_HOLD);
            end
         end
         PH_ASK: begin
            if (slot_end) begin
               phase_d  = PH_BRIDGE;
               tmr_load = 1'b1;
               tmr_span = SPAN_W'(LP_HOLD);
            end
         end
         PH_BRIDGE: begin
            if (slot_end) begin
               phase_d  = PH_LEADER;
               tmr_load = 1'b1;
               tmr_span = SPAN_W'(BYTE_W);
            end
         end
         PH_LEADER, PH_PAYLOAD: begin
            if (!slot_end) begin
               sh_shift = (phase_q == PH_PAYLOAD);
            end else if (in_ready && in_valid) begin
               phase_d  = PH_PAYLOAD;
               tmr_load = 1'b1;
               tmr_span = SPAN_W'(BYTE_W);
               sh_load  = 1'b1;
            end else begin
               phase_d  = PH_TRAIL;
               tmr_load = 1'b1;
               tmr_span = SPAN_W'(TRAIL_LEN);
               uf_d     = in_ready;
            end
         end
         PH_TRAIL: begin
            if (slot_end)
               phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         last_q  <= 1'b0;
         trail_q <= 1'b0;
         uf_q    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         uf_q    <= uf_d;
         if (sh_load)
            last_q <= in_last;
         if ((phase_d == PH_TRAIL) && (phase_q != PH_TRAIL))
            trail_q <= ~cur_bit;
      end
   end

   assign lead_idx = 3'd7 - 3'(slot);

   always_comb begin
      case (phase_q)
         PH_LEADER:  cur_bit = LEADER_SERIAL[lead_idx];
         PH_PAYLOAD: cur_bit = sh_bit;
         default:    cur_bit = 1'b0;
      endcase
   end

   assign lp_p      = (phase_q == PH_IDLE);
   assign lp_n      = (phase_q == PH_IDLE) || (phase_q == PH_ASK);
   assign hs_en     = (phase_q == PH_LEADER) || (phase_q == PH_PAYLOAD) ||
                      (phase_q == PH_TRAIL);
   assign hs_bit    = (phase_q == PH_TRAIL) ? trail_q : cur_bit;
   assign underflow = uf_q;

   assert_lines_low_in_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en |-> (!lp_p && !lp_n));

   assert_bridge_after_ask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lp_n) && !lp_p) |-> $past(!lp_p));

   assert_hs_after_bridge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(!lp_p && !lp_n));

   assert_ready_only_in_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> hs_en);

   assert_underflow_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> $past(in_ready && !in_valid));

   assert_stop_after_trail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_en) |-> (lp_p && lp_n));

endmodule

// File: tb/hs_lane_seq_tb_top.sv
module hs_lane_seq_tb_top;

   localparam int LP = 2;
   localparam int TR = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [7:0] in_data;
   logic       in_valid;
   logic       in_last;
   logic       in_ready, lp_p, lp_n, hs_en, hs_bit, underflow;

   int vectors     = 0;
   int miscompares = 0;
   bit done        = 1'b0;

   always #5 clk = ~clk;

   hs_lane_seq #(.LP_HOLD(LP), .TRAIL_LEN(TR), .MSB_FIRST(1'b0)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_ready  (in_ready),
      .lp_p      (lp_p),
      .lp_n      (lp_n),
      .hs_en     (hs_en),
      .hs_bit    (hs_bit),
      .underflow (underflow)
   );

   function automatic logic [7:0] pat(int seed, int i);
      if (seed == 8) return 8'h00;
      if (seed == 9) return 8'hFF;
      return 8'((seed * 83 + i * 53 + 17) % 256);
   endfunction

   function automatic logic leader_bit(int s);
      case (s)
         3, 4, 5, 7: return 1'b1;
         default:    return 1'b0;
      endcase
   endfunction

   task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // packed as {2'b0, lp_p, lp_n, hs_en, hs_bit, in_ready, underflow}
   function automatic logic [7:0] outs();
      return {2'b00, lp_p, lp_n, hs_en, hs_bit, in_ready, underflow};
   endfunction

   task automatic run_burst(int n, int uf_at, int seed, bit poke);
      int         sent;
      int         ptr;
      int         pay0, trail0, total;
      bit         hs_pend;
      logic       lastbit;
      logic [7:0] tmp;
      logic [7:0] rec [4];
      logic [7:0] e;
      string      tag;
      sent    = (uf_at >= 0) ? uf_at : n;
      ptr     = 0;
      pay0    = 2 * LP + 8;
      trail0  = pay0 + 8 * sent;
      total   = trail0 + TR + 3;
      hs_pend = 1'b0;
      if (sent == 0) lastbit = 1'b1;
      else begin
         tmp     = pat(seed, sent - 1);
         lastbit = tmp[7];
      end
      @(negedge clk);
      start    = 1'b1;
      in_data  = pat(seed, 0);
      in_valid = (uf_at != 0);
      in_last  = (n == 1);
      for (int c = 1; c <= total; c++) begin
         @(posedge clk);
         #1;
         if (hs_pend) begin
            ptr++;
            in_data  = pat(seed, ptr);
            in_valid = (ptr < n) && (ptr != uf_at);
            in_last  = (ptr == n - 1);
         end
         if ((!poke && c == 1) || (poke && c == pay0)) start = 1'b0;
         @(negedge clk);
         if (c <= LP) begin
            e = 8'b0001_0000; tag = "R2 ask";
         end else if (c <= 2 * LP) begin
            e = 8'b0000_0000; tag = "R2 bridge";
         end else if (c <= pay0) begin
            int s = c - 2 * LP - 1;
            e = {4'b0000, 1'b1, leader_bit(s), (s == 7), 1'b0};
            tag = "R4 R3 R6 leader";
         end else if (c <= trail0) begin
            int d = c - pay0 - 1;
            int b = d / 8;
            int i = d % 8;
            tmp = pat(seed, b);
            e = {4'b0000, 1'b1, tmp[i], (i == 7) && (b < n - 1), 1'b0};
            tag = "R5 R3 R6 payload";
            rec[b][i] = hs_bit;
         end else if (c <= trail0 + TR) begin
            bit uf = (uf_at >= 0) && (c == trail0 + 1);
            e = {4'b0000, 1'b1, ~lastbit, 1'b0, uf};
            tag = (uf_at >= 0) ? "R9 R3 trail" : "R7 R3 trail";
         end else begin
            e = 8'b0011_0000; tag = "R8 stop";
         end
         if (poke) tag = {tag, " R10"};
         check(tag, outs(), e);
         hs_pend = in_ready && in_valid;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      for (int b = 0; b < sent; b++)
         check("R5 deserialized byte", rec[b], pat(seed, b));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R8 watchdog: got no finish expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      start    = 1'b0;
      in_data  = 8'h00;
      in_valid = 1'b0;
      in_last  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset", outs(), 8'b0011_0000);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R1 idle", outs(), 8'b0011_0000);
      end
      for (int n = 1; n <= 4; n++) begin
         run_burst(n, -1, 0, 1'b0);
         run_burst(n, -1, 1, 1'b0);
         run_burst(n, -1, 8, 1'b0);
         run_burst(n, -1, 9, 1'b0);
      end
      run_burst(2, -1, 3, 1'b1);
      run_burst(3, 0, 5, 1'b0);
      run_burst(3, 1, 6, 1'b0);
      run_burst(3, 2, 9, 1'b0);
      run_burst(4, 3, 8, 1'b0);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check("R8 stays idle", outs(), 8'b0011_0000);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule